// File: doc/BRIEF.md
# Option Setting Commit Unit

The unit keeps two copies of the device option settings: a current image that the flash front-end obeys, and a pending image that software edits. The settings are a read-protection level byte and a per-sector-group write-protection mask. Software first opens the option registers with a two-key sequence, then edits the pending image, then sets a start bit. The unit goes busy for a fixed number of cycles and afterwards copies the whole pending image into the current image in one step.

One change is forbidden: once the current protection level is the top level, it may not be lowered. A commit that tries to lower it is refused. The refusal sets a sticky error flag, leaves the current image untouched and reloads the pending image from the current image. The unit shares its register bus with the flash front-end, so the register offsets are fixed.

Top module: `opt_commit_unit`

## Requirements
- R1: After reset the option lock is set, busy and the error flag are 0, the current protection byte is RST_RDP (default 0xAA), the current mask is RST_WP (default 0xFF), and the pending image equals the current image.
- R2: Writing 0x08192A3B and then 0x4C5D6E7F to offset 0x08 clears the lock, which reads at bit 0 of offset 0x18. Any other value, or the wrong order, leaves the lock set. Writing 1 to bit 0 of offset 0x18 sets the lock again.
- R3: The read map is as follows. Offset 0x1C gives busy at bit 0, the current protection byte at bits 15:8 and the error flag at bit 30. Offset 0x20 gives the pending protection byte at bits 15:8. Offsets 0x38 and 0x3C give the current and pending masks in their low bits. Offset 0x18 gives the lock at bit 0. Every other offset reads as 0.
- R4: Writing 1 to bit 1 of offset 0x18 (with bit 0 clear) while unlocked and idle makes busy read 1 for exactly COMMIT_CYCLES cycles. When busy falls, the current image equals the pending image.
- R5: Writes to the pending registers (bits 15:8 at 0x20, mask at 0x3C) do not change the current image before a commit completes.
- R6: A commit with current byte 0xCC and a pending byte other than 0xCC is refused. The error flag is set, the current image is unchanged and the pending image is reloaded from the current image.
- R7: Writes to the pending registers and the start bit have no effect while the lock is set or while busy.
- R8: Writing 1 to bit 30 of offset 0x24 clears the error flag. Writing 0 there has no effect.
- R9: rdp_level_o is 0 for current byte 0xAA, 2 for 0xCC and 1 for any other value. wp_mask_o is the current mask, where a 1 means the group is unprotected.
- R10: Commits that raise the level, from 0 to 1 and from 1 to 2, are accepted.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| busy_o | output | 1 | Commit in progress |
| rdp_level_o | output | 2 | Decoded current protection level |
| wp_mask_o | output | WP_W | Current write-protection mask |

## Verification
The assertions check five properties on every cycle:
- a busy period, once started, does not end early;
- the current image changes only at the end of a commit;
- the top level never decays;
- the pending image stays frozen while locked;
- a relock or an error clear takes effect on the next cycle.

Only the bench scenarios can show the rest: that the exact key pair and its order are needed, the precise length of the busy window, the contents of the read map, and the pending image being reloaded after a refused commit.

// File: rtl/opt_unit_pkg.sv
package opt_unit_pkg;
  localparam logic [31:0] UNLOCK_KEY_A = 32'h0819_2A3B;
  localparam logic [31:0] UNLOCK_KEY_B = 32'h4C5D_6E7F;

  localparam logic [7:0] OFS_KEY       = 8'h08;
  localparam logic [7:0] OFS_CTRL      = 8'h18;
  localparam logic [7:0] OFS_CUR_STAT  = 8'h1C;
  localparam logic [7:0] OFS_PEND_STAT = 8'h20;
  localparam logic [7:0] OFS_CLR       = 8'h24;
  localparam logic [7:0] OFS_CUR_WP    = 8'h38;
  localparam logic [7:0] OFS_PEND_WP   = 8'h3C;

  localparam int LOCK_BIT  = 0;
  localparam int START_BIT = 1;
  localparam int BUSY_BIT  = 0;
  localparam int ERR_BIT   = 30;
  localparam int RDP_LSB   = 8;

  localparam logic [7:0] RDP_OPEN   = 8'hAA;
  localparam logic [7:0] RDP_FROZEN = 8'hCC;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_GUARDED = 2'd1,
    LVL_FROZEN  = 2'd2
  } prot_level_e;

  function automatic prot_level_e decode_level(logic [7:0] code);
    case (code)
      RDP_OPEN:   return LVL_OPEN;
      RDP_FROZEN: return LVL_FROZEN;
      default:    return LVL_GUARDED;
    endcase
  endfunction
endpackage

// File: rtl/opt_key_lock.sv
module opt_key_lock
  import opt_unit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic        relock_i,
  input  logic [31:0] key_i,
  output logic        locked_o
);
  logic locked_q, stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      stage_q  <= 1'b0;
    end else if (relock_i) begin
      locked_q <= 1'b1;
      stage_q  <= 1'b0;
    end else if (key_wr_i && locked_q) begin
      if (!stage_q && key_i == UNLOCK_KEY_A) begin
        stage_q <= 1'b1;
      end else if (stage_q && key_i == UNLOCK_KEY_B) begin
        locked_q <= 1'b0;
        stage_q  <= 1'b0;
      end else begin
        stage_q <= 1'b0;
      end
    end
  end

  assign locked_o = locked_q;

  p_relock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> locked_o);
  p_open_needs_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && !key_wr_i |=> locked_o);
endmodule

// File: rtl/opt_commit_timer.sv
module opt_commit_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  initial begin
    a_cycles_pos: assert (CYCLES >= 1);
  end

  p_busy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q);
  p_done_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/opt_image_store.sv
module opt_image_store
  import opt_unit_pkg::*;
#(
  parameter int              WP_W    = 8,
  parameter logic [7:0]      RST_RDP = 8'hAA,
  parameter logic [WP_W-1:0] RST_WP  = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic            pend_rdp_we_i,
  input  logic            pend_wp_we_i,
  input  logic [7:0]      rdp_wdata_i,
  input  logic [WP_W-1:0] wp_wdata_i,
  input  logic            done_i,
  input  logic            clr_err_i,
  output logic [7:0]      cur_rdp_o,
  output logic [WP_W-1:0] cur_wp_o,
  output logic [7:0]      pend_rdp_o,
  output logic [WP_W-1:0] pend_wp_o,
  output logic            err_o
);
  logic [7:0]      cur_rdp_q, pend_rdp_q;
  logic [WP_W-1:0] cur_wp_q, pend_wp_q;
  logic            err_q;
  logic            refuse;

  // lowering the frozen level is never allowed
  assign refuse = (cur_rdp_q == RDP_FROZEN) && (pend_rdp_q != RDP_FROZEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_rdp_q  <= RST_RDP;
      cur_wp_q   <= RST_WP;
      pend_rdp_q <= RST_RDP;
      pend_wp_q  <= RST_WP;
      err_q      <= 1'b0;
    end else begin
      if (done_i && refuse) begin
        pend_rdp_q <= cur_rdp_q;
        pend_wp_q  <= cur_wp_q;
        err_q      <= 1'b1;
      end else begin
        if (done_i) begin
          cur_rdp_q <= pend_rdp_q;
          cur_wp_q  <= pend_wp_q;
        end
        if (pend_rdp_we_i) pend_rdp_q <= rdp_wdata_i;
        if (pend_wp_we_i)  pend_wp_q  <= wp_wdata_i;
        if (clr_err_i)     err_q      <= 1'b0;
      end
    end
  end

  assign cur_rdp_o  = cur_rdp_q;
  assign cur_wp_o   = cur_wp_q;
  assign pend_rdp_o = pend_rdp_q;
  assign pend_wp_o  = pend_wp_q;
  assign err_o      = err_q;

  p_cur_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(cur_rdp_q) && $stable(cur_wp_q));
  p_frozen_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_rdp_q == RDP_FROZEN |=> cur_rdp_q == RDP_FROZEN);
  p_pend_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !done_i |=> $stable(pend_rdp_q) && $stable(pend_wp_q));
  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_i && !done_i |=> !err_q);
endmodule

// File: rtl/opt_commit_unit.sv
module opt_commit_unit
  import opt_unit_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              WP_W          = 8,
  parameter int              COMMIT_CYCLES = 16,
  parameter logic [7:0]      RST_RDP       = 8'hAA,
  parameter logic [WP_W-1:0] RST_WP        = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic [1:0]        rdp_level_o,
  output logic [WP_W-1:0]   wp_mask_o
);
  logic            locked, busy, done, err;
  logic            wr_key, wr_ctrl, wr_clr, wr_pend_stat, wr_pend_wp;
  logic            relock, start, edit_ok;
  logic [7:0]      cur_rdp, pend_rdp;
  logic [WP_W-1:0] cur_wp, pend_wp;

  assign wr_key       = wr_en_i && addr_i == ADDR_W'(OFS_KEY);
  assign wr_ctrl      = wr_en_i && addr_i == ADDR_W'(OFS_CTRL);
  assign wr_clr       = wr_en_i && addr_i == ADDR_W'(OFS_CLR);
  assign wr_pend_stat = wr_en_i && addr_i == ADDR_W'(OFS_PEND_STAT);
  assign wr_pend_wp   = wr_en_i && addr_i == ADDR_W'(OFS_PEND_WP);

  assign edit_ok = !locked && !busy;
  assign relock  = wr_ctrl && wdata_i[LOCK_BIT];
  assign start   = wr_ctrl && wdata_i[START_BIT] && !wdata_i[LOCK_BIT] && edit_ok;

  opt_key_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (wr_key),
    .relock_i (relock),
    .key_i    (wdata_i),
    .locked_o (locked)
  );

  opt_commit_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  opt_image_store #(.WP_W(WP_W), .RST_RDP(RST_RDP), .RST_WP(RST_WP)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lock_i        (locked),
    .pend_rdp_we_i (wr_pend_stat && edit_ok),
    .pend_wp_we_i  (wr_pend_wp && edit_ok),
    .rdp_wdata_i   (wdata_i[RDP_LSB +: 8]),
    .wp_wdata_i    (wdata_i[WP_W-1:0]),
    .done_i        (done),
    .clr_err_i     (wr_clr && wdata_i[ERR_BIT]),
    .cur_rdp_o     (cur_rdp),
    .cur_wp_o      (cur_wp),
    .pend_rdp_o    (pend_rdp),
    .pend_wp_o     (pend_wp),
    .err_o         (err)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_CTRL):      rdata_o[LOCK_BIT] = locked;
      ADDR_W'(OFS_CUR_STAT): begin
        rdata_o[BUSY_BIT]         = busy;
        rdata_o[RDP_LSB +: 8]     = cur_rdp;
        rdata_o[ERR_BIT]          = err;
      end
      ADDR_W'(OFS_PEND_STAT): rdata_o[RDP_LSB +: 8] = pend_rdp;
      ADDR_W'(OFS_CUR_WP):    rdata_o[WP_W-1:0]    = cur_wp;
      ADDR_W'(OFS_PEND_WP):   rdata_o[WP_W-1:0]    = pend_wp;
      default:                rdata_o = '0;
    endcase
  end

  assign busy_o      = busy;
  assign rdp_level_o = decode_level(cur_rdp);
  assign wp_mask_o   = cur_wp;

  p_no_start_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && !busy |=> !busy);
  p_level_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdp_level_o != 2'd3);
endmodule

// File: tb/opt_commit_unit_test.sv
module opt_commit_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  logic [1:0]  level;
  logic [7:0]  wp;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opt_commit_unit #(.COMMIT_CYCLES(NCYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
    .rdp_level_o(level), .wp_mask_o(wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic unlock();
    bus_wr(8'h08, 32'h0819_2A3B);
    bus_wr(8'h08, 32'h4C5D_6E7F);
  endtask

  task automatic commit(output int cyc);
    bus_wr(8'h18, 32'h2);
    #1;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h18, d); chk("R1 lock", d, 32'h1);
    bus_rd(8'h1C, d); chk("R1 cur stat", d, 32'h0000_AA00);
    bus_rd(8'h20, d); chk("R1 pend stat", d, 32'h0000_AA00);
    bus_rd(8'h38, d); chk("R1 cur wp", d, 32'hFF);
    bus_rd(8'h3C, d); chk("R1 pend wp", d, 32'hFF);
    chk("R9 level open", 32'(level), 32'd0);
    bus_rd(8'h40, d); chk("R3 unmapped", d, 32'h0);
  endtask

  task automatic t_locked_ignore();
    logic [31:0] d;
    bus_wr(8'h3C, 32'h0F);
    bus_rd(8'h3C, d); chk("R7 pend wp locked", d, 32'hFF);
    bus_wr(8'h20, 32'h0000_1100);
    bus_rd(8'h20, d); chk("R7 pend stat locked", d, 32'h0000_AA00);
    bus_wr(8'h18, 32'h2);
    #1 chk("R7 start locked", 32'(busy), 32'd0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    bus_wr(8'h08, 32'h4C5D_6E7F);
    bus_wr(8'h08, 32'h0819_2A3B);
    bus_rd(8'h18, d); chk("R2 wrong order", d, 32'h1);
    bus_wr(8'h08, 32'h1234_5678);
    bus_wr(8'h08, 32'h0819_2A3B);
    bus_wr(8'h08, 32'h0000_0000);
    bus_wr(8'h08, 32'h4C5D_6E7F);
    bus_rd(8'h18, d); chk("R2 broken pair", d, 32'h1);
    unlock();
    bus_rd(8'h18, d); chk("R2 unlocked", d, 32'h0);
  endtask

  task automatic t_commit_wp();
    logic [31:0] d;
    int cyc;
    bus_wr(8'h3C, 32'h5A);
    bus_rd(8'h3C, d); chk("R3 pend wp", d, 32'h5A);
    bus_rd(8'h38, d); chk("R5 cur wp before", d, 32'hFF);
    commit(cyc);
    chk("R4 busy length", 32'(cyc), 32'(NCYC));
    bus_rd(8'h38, d); chk("R4 cur wp after", d, 32'h5A);
    chk("R9 wp_mask_o", 32'(wp), 32'h5A);
  endtask

  task automatic t_guarded();
    logic [31:0] d;
    int cyc;
    bus_wr(8'h20, 32'h0000_1100);
    bus_rd(8'h1C, d); chk("R5 cur stat before", d, 32'h0000_AA00);
    commit(cyc);
    bus_rd(8'h1C, d); chk("R10 level1 accepted", d, 32'h0000_1100);
    chk("R9 level guarded", 32'(level), 32'd1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int cyc;
    bus_wr(8'h18, 32'h2);
    bus_wr(8'h3C, 32'h00);
    bus_rd(8'h3C, d); chk("R7 pend wp busy", d, 32'h5A);
    cyc = 0;
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    bus_rd(8'h38, d); chk("R7 cur wp busy", d, 32'h5A);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    int cyc;
    bus_wr(8'h20, 32'h0000_CC00);
    commit(cyc);
    chk("R10 level2 accepted", 32'(level), 32'd2);
    bus_wr(8'h20, 32'h0000_AA00);
    bus_wr(8'h3C, 32'h33);
    commit(cyc);
    bus_rd(8'h1C, d); chk("R6 refused stat", d, 32'h4000_CC00);
    chk("R6 level kept", 32'(level), 32'd2);
    bus_rd(8'h38, d); chk("R6 cur wp kept", d, 32'h5A);
    bus_rd(8'h20, d); chk("R6 pend stat reload", d, 32'h0000_CC00);
    bus_rd(8'h3C, d); chk("R6 pend wp reload", d, 32'h5A);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    bus_wr(8'h24, 32'h0);
    bus_rd(8'h1C, d); chk("R8 zero write", d, 32'h4000_CC00);
    bus_wr(8'h24, 32'h4000_0000);
    bus_rd(8'h1C, d); chk("R8 cleared", d, 32'h0000_CC00);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    bus_wr(8'h18, 32'h1);
    bus_rd(8'h18, d); chk("R2 relocked", d, 32'h1);
    bus_wr(8'h3C, 32'h77);
    bus_rd(8'h3C, d); chk("R7 after relock", d, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_ignore();
    t_keys();
    t_commit_wp();
    t_guarded();
    t_busy_ignore();
    t_frozen();
    t_clear();
    t_relock();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule